// File: doc/BRIEF.md
# Configurable Host-Bus Port Cell

This block is one 8-bit port that a host microcontroller reconfigures at run time. Each pin can be a plain output, a driver of latched address bits, or an input. The whole port can also be switched into one of three port-wide modes. Address-in mode captures the pin values while the address strobe is high and passes them on to decode logic. Data-port mode turns the pins into the data bus of a host with a non-multiplexed bus. Peripheral mode makes the port a bidirectional buffer between the host data bus and an external 8-bit peripheral. That buffer is enabled only while one of two peripheral-select lines is active.

The address-out function takes its bits from an internal address latch. That latch follows the host's multiplexed address/data bus while the address strobe is high and holds the value once the strobe goes low. Which address nibble appears on each half of the port depends on the host bus type and on whether this cell is the last port of the chip. Several instances with different `LAST_PORT` settings together cover a wide host address. All pad and host-side drive outputs are registered. Reset clears every configuration register, so every pad comes up as an input.

Top module: `mcu_port_cell`

## Requirements
- R1: A synchronous reset clears the direction, control, output-enable, mode and output-data registers, the address latch and `addr_in_q`; the cycle after reset `pad_oe`, `pad_out`, `host_doe` and `host_dout` are all zero.
- R2: The address latch loads `host_ad` on every clock edge where `ale` is 1 and holds its value on every edge where `ale` is 0.
- R3: In pin-level mode (mode bits 7, 6 and 5 all 0), pin i is an address-out pin when `oe[i]` is 1, or when `dir[i]` and `ctl[i]` are both 1. If an address nibble is assigned to its half, the pin drives that nibble's bit; otherwise it is not driven.
- R4: The nibble assigned to each half depends on `bus_type`: 0 (8-bit multiplexed) gives the low half address bits 3:0 and the high half bits 7:4. 1 (8-bit non-multiplexed) gives the same, but only when LAST_PORT=1. 2 (page mode) gives bits 11:8 low and 15:12 high, only when LAST_PORT=1. 3 (16-bit multiplexed) gives the high half bits 7:4 when LAST_PORT=0, and the low half bits 11:8 when LAST_PORT=1. All other halves get no nibble.
- R5: In pin-level mode, a pin with `dir`=1, `ctl`=0 and `oe`=0 drives its bit of the output-data register; a pin with `dir`=0 and `oe`=0 is not driven.
- R6: Address-in mode (mode bit 5, with bits 7 and 6 clear) releases all pads, loads `pad_in` into `addr_in_q` on edges where `ale` is 1, and holds `addr_in_q` otherwise, including in every other mode.
- R7: Peripheral mode (mode bit 7) with a select active drives every pad with `host_ad[7:0]` while `wr_stb` is 1. When `rd_stb` is 1 and `wr_stb` is 0, it sets `host_doe` and returns `pad_in` on `host_dout`.
- R8: In peripheral mode with both `psel` lines low, or with neither strobe active, no pad and no host-side output is driven.
- R9: Data-port mode (mode bit 6, bit 7 clear) ignores the direction, control, output-enable and output-data registers. While `rd_stb` is 1 it drives every pad with `core_rdata`. While `wr_stb` is 1 and `rd_stb` is 0 it sets `host_doe` and returns `pad_in`.
- R10: Mode priority is peripheral, then data port, then address-in, then pin-level. At most one source drives any pin in a cycle.
- R11: Configuration writes use `cfg_addr` 0=direction, 1=control, 2=output-enable, 3=mode, 4=output-data. Other addresses change nothing. The outputs change one cycle after the inputs or registers that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ad | input | AW | Host multiplexed address/data bus |
| ale | input | 1 | Address strobe, active high |
| rd_stb | input | 1 | Host read strobe, active high |
| wr_stb | input | 1 | Host write strobe, active high |
| bus_type | input | 2 | Host bus type (encoding in R4) |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | PW | Configuration write data |
| psel | input | 2 | Peripheral-select lines |
| core_rdata | input | PW | Read data put on the pads in data-port mode |
| pad_in | input | PW | Pad input values |
| pad_out | output | PW | Pad output values |
| pad_oe | output | PW | Pad output enables |
| host_dout | output | PW | Data returned toward the host |
| host_doe | output | 1 | Host-side drive enable |
| addr_in_q | output | PW | Latched address-in value |

## Verification
The assertions watch several rules on every cycle. They check the one-source-per-pin rule and that the address latch and `addr_in_q` hold while the strobe is low. They also check that the peripheral buffer stays released while both selects are low and that the pads are quiet in data-port mode without a read. Whether the right address nibble reaches each half for each bus type can only be shown by the bench's scenarios. The same holds for the correct output-data bits on GPIO pins, the cycle where the peripheral direction flips with the strobes, and the mode priority when several mode bits are set. Those scenarios run on one last-port and one non-last-port instance against a behavioural model.

// File: rtl/mcu_port_pkg.sv
package mcu_port_pkg;
  typedef enum logic [1:0] {
    BUS_MUX8  = 2'd0,
    BUS_NMUX8 = 2'd1,
    BUS_PAGE  = 2'd2,
    BUS_MUX16 = 2'd3
  } bus_kind_e;

  localparam logic [2:0] CFG_DIR  = 3'd0;
  localparam logic [2:0] CFG_CTL  = 3'd1;
  localparam logic [2:0] CFG_OE   = 3'd2;
  localparam logic [2:0] CFG_MODE = 3'd3;
  localparam logic [2:0] CFG_DOUT = 3'd4;

  localparam int MODE_PERIPH = 7;
  localparam int MODE_DPORT  = 6;
  localparam int MODE_AIN    = 5;
endpackage

// File: rtl/port_cfg_regs.sv
module port_cfg_regs
  import mcu_port_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] dir_q,
  output logic [PW-1:0] ctl_q,
  output logic [PW-1:0] oe_q,
  output logic [PW-1:0] mode_q,
  output logic [PW-1:0] dout_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      ctl_q  <= '0;
      oe_q   <= '0;
      mode_q <= '0;
      dout_q <= '0;
    end else if (we) begin
      case (addr)
        CFG_DIR:  dir_q  <= wdata;
        CFG_CTL:  ctl_q  <= wdata;
        CFG_OE:   oe_q   <= wdata;
        CFG_MODE: mode_q <= wdata;
        CFG_DOUT: dout_q <= wdata;
        default: ;
      endcase
    end
  end

  // R11: an unmapped address leaves every register untouched
  p_unmapped_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (we && addr > CFG_DOUT) |=> ($stable(dir_q) && $stable(ctl_q) && $stable(oe_q)
                                 && $stable(mode_q) && $stable(dout_q)));
endmodule

// File: rtl/port_addr_latch.sv
module port_addr_latch #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic [AW-1:0] host_ad,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)      addr_q <= '0;
    else if (ale) addr_q <= host_ad;
  end

  p_latch_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(addr_q));
  p_latch_load_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> addr_q == $past(host_ad));
endmodule

// File: rtl/port_addr_map.sv
module port_addr_map
  import mcu_port_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PW        = 8,
  parameter bit LAST_PORT = 1'b1
) (
  input  bus_kind_e       bus_kind,
  input  logic [AW-1:0]   addr,
  output logic [PW/2-1:0] lo_nib,
  output logic            lo_vld,
  output logic [PW/2-1:0] hi_nib,
  output logic            hi_vld
);
  localparam int HALF = PW / 2;

  generate
    if (LAST_PORT) begin : g_last
      always_comb begin
        lo_nib = '0; hi_nib = '0; lo_vld = 1'b0; hi_vld = 1'b0;
        case (bus_kind)
          BUS_MUX8, BUS_NMUX8: begin
            lo_nib = addr[HALF-1:0];      lo_vld = 1'b1;
            hi_nib = addr[2*HALF-1:HALF]; hi_vld = 1'b1;
          end
          BUS_PAGE: begin
            lo_nib = addr[3*HALF-1:2*HALF]; lo_vld = 1'b1;
            hi_nib = addr[4*HALF-1:3*HALF]; hi_vld = 1'b1;
          end
          BUS_MUX16: begin
            lo_nib = addr[3*HALF-1:2*HALF]; lo_vld = 1'b1;
          end
          default: ;
        endcase
      end
    end else begin : g_inner
      always_comb begin
        lo_nib = '0; hi_nib = '0; lo_vld = 1'b0; hi_vld = 1'b0;
        case (bus_kind)
          BUS_MUX8: begin
            lo_nib = addr[HALF-1:0];      lo_vld = 1'b1;
            hi_nib = addr[2*HALF-1:HALF]; hi_vld = 1'b1;
          end
          BUS_MUX16: begin
            hi_nib = addr[2*HALF-1:HALF]; hi_vld = 1'b1;
          end
          default: ;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/mcu_port_cell.sv
module mcu_port_cell
  import mcu_port_pkg::*;
#(
  parameter int PW        = 8,
  parameter int AW        = 16,
  parameter bit LAST_PORT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] host_ad,
  input  logic          ale,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [1:0]    bus_type,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [PW-1:0] cfg_wdata,
  input  logic [1:0]    psel,
  input  logic [PW-1:0] core_rdata,
  input  logic [PW-1:0] pad_in,
  output logic [PW-1:0] pad_out,
  output logic [PW-1:0] pad_oe,
  output logic [PW-1:0] host_dout,
  output logic          host_doe,
  output logic [PW-1:0] addr_in_q
);
  localparam int HALF = PW / 2;

  logic [PW-1:0] dir_q, ctl_q, oe_q, mode_q, dout_q;
  logic [AW-1:0] alat_q;
  logic [HALF-1:0] lo_nib, hi_nib;
  logic lo_vld, hi_vld;

  port_cfg_regs #(.PW(PW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .dir_q(dir_q), .ctl_q(ctl_q), .oe_q(oe_q), .mode_q(mode_q), .dout_q(dout_q)
  );

  port_addr_latch #(.AW(AW)) u_alat (
    .clk(clk), .rst(rst), .ale(ale), .host_ad(host_ad), .addr_q(alat_q)
  );

  port_addr_map #(.AW(AW), .PW(PW), .LAST_PORT(LAST_PORT)) u_map (
    .bus_kind(bus_kind_e'(bus_type)), .addr(alat_q),
    .lo_nib(lo_nib), .lo_vld(lo_vld), .hi_nib(hi_nib), .hi_vld(hi_vld)
  );

  logic pb_mode, dp_mode, ain_mode, psel_any;
  logic pb_drv, dp_drv;
  logic [PW-1:0] sel_gpio, sel_aout;
  logic [PW-1:0] nxt_out, nxt_oe, nxt_hdout;
  logic nxt_hdoe;

  assign psel_any = |psel;
  assign pb_mode  = mode_q[MODE_PERIPH];
  assign dp_mode  = !pb_mode && mode_q[MODE_DPORT];
  assign ain_mode = !pb_mode && !dp_mode && mode_q[MODE_AIN];

  always_comb begin
    sel_gpio  = '0;
    sel_aout  = '0;
    pb_drv    = 1'b0;
    dp_drv    = 1'b0;
    nxt_out   = '0;
    nxt_oe    = '0;
    nxt_hdout = '0;
    nxt_hdoe  = 1'b0;
    if (pb_mode) begin
      if (psel_any && wr_stb) begin
        pb_drv  = 1'b1;
        nxt_oe  = '1;
        nxt_out = host_ad[PW-1:0];
      end else if (psel_any && rd_stb) begin
        nxt_hdoe  = 1'b1;
        nxt_hdout = pad_in;
      end
    end else if (dp_mode) begin
      if (rd_stb) begin
        dp_drv  = 1'b1;
        nxt_oe  = '1;
        nxt_out = core_rdata;
      end else if (wr_stb) begin
        nxt_hdoe  = 1'b1;
        nxt_hdout = pad_in;
      end
    end else if (!ain_mode) begin
      for (int i = 0; i < PW; i++) begin
        if (oe_q[i] || (dir_q[i] && ctl_q[i])) begin
          if (i < HALF) begin
            sel_aout[i] = lo_vld;
            nxt_out[i]  = lo_vld & lo_nib[i % HALF];
          end else begin
            sel_aout[i] = hi_vld;
            nxt_out[i]  = hi_vld & hi_nib[i % HALF];
          end
          nxt_oe[i] = sel_aout[i];
        end else if (dir_q[i] && !ctl_q[i]) begin
          sel_gpio[i] = 1'b1;
          nxt_oe[i]   = 1'b1;
          nxt_out[i]  = dout_q[i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out   <= '0;
      pad_oe    <= '0;
      host_dout <= '0;
      host_doe  <= 1'b0;
      addr_in_q <= '0;
    end else begin
      pad_out   <= nxt_out;
      pad_oe    <= nxt_oe;
      host_dout <= nxt_hdout;
      host_doe  <= nxt_hdoe;
      if (ain_mode && ale) addr_in_q <= pad_in;
    end
  end

  // R1: outputs are quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && !host_doe && addr_in_q == '0));

  // R8: peripheral buffer released while no select is active
  p_pbuf_off_r8: assert property (@(posedge clk) disable iff (rst)
    (pb_mode && !psel_any) |=> (pad_oe == '0 && !host_doe));

  // R9: data port leaves the pads alone unless read strobe is active
  p_dport_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (dp_mode && !rd_stb) |=> pad_oe == '0);

  // R6: address-in value holds without strobe
  p_ain_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(addr_in_q));
  p_ain_load_r6: assert property (@(posedge clk) disable iff (rst)
    (ain_mode && ale) |=> addr_in_q == $past(pad_in));

  // R10: at most one source per pin
  for (genvar g = 0; g < PW; g++) begin : g_src
    p_one_src_r10: assert property (@(posedge clk) disable iff (rst)
      $onehot0({sel_gpio[g], sel_aout[g], dp_drv, pb_drv}));
  end
endmodule

// File: tb/tb_mcu_port_cell.sv
`timescale 1ns/1ps
module tb_mcu_port_cell;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic [15:0] host_ad = '0;
  logic ale = 0, rd_stb = 0, wr_stb = 0, cfg_we = 0;
  logic [1:0] bus_type = '0, psel = '0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0, core_rdata = '0, pad_in = '0;

  logic [7:0] po_l, oe_l, hd_l, ain_l, po_i, oe_i, hd_i, ain_i;
  logic hde_l, hde_i;

  mcu_port_cell #(.PW(8), .AW(16), .LAST_PORT(1'b1)) dut (
    .clk(clk), .rst(rst), .host_ad(host_ad), .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .bus_type(bus_type), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .psel(psel), .core_rdata(core_rdata), .pad_in(pad_in), .pad_out(po_l), .pad_oe(oe_l),
    .host_dout(hd_l), .host_doe(hde_l), .addr_in_q(ain_l));

  mcu_port_cell #(.PW(8), .AW(16), .LAST_PORT(1'b0)) dut_inner (
    .clk(clk), .rst(rst), .host_ad(host_ad), .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .bus_type(bus_type), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .psel(psel), .core_rdata(core_rdata), .pad_in(pad_in), .pad_out(po_i), .pad_oe(oe_i),
    .host_dout(hd_i), .host_doe(hde_i), .addr_in_q(ain_i));

  int tests = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference state
  logic [7:0] m_reg [5];
  logic [15:0] m_lat;
  logic [24:0] exp_l, exp_i;
  logic [7:0] exp_ain;

  function automatic logic [24:0] model(bit last);
    logic [7:0] o, e, hd;
    logic he;
    int lo_src, hi_src, src;
    bit pb, dp, ai;
    o = 0; e = 0; hd = 0; he = 0;
    pb = m_reg[3][7];
    dp = !pb && m_reg[3][6];
    ai = !pb && !dp && m_reg[3][5];
    case (bus_type)
      2'd0: begin lo_src = 0; hi_src = 4; end
      2'd1: begin lo_src = last ? 0 : -1; hi_src = last ? 4 : -1; end
      2'd2: begin lo_src = last ? 8 : -1; hi_src = last ? 12 : -1; end
      default: begin lo_src = last ? 8 : -1; hi_src = last ? -1 : 4; end
    endcase
    if (pb) begin
      if (psel != 0 && wr_stb) begin e = 8'hFF; o = host_ad[7:0]; end
      else if (psel != 0 && rd_stb) begin he = 1; hd = pad_in; end
    end else if (dp) begin
      if (rd_stb) begin e = 8'hFF; o = core_rdata; end
      else if (wr_stb) begin he = 1; hd = pad_in; end
    end else if (!ai) begin
      for (int i = 0; i < 8; i++) begin
        if (m_reg[2][i] || (m_reg[0][i] && m_reg[1][i])) begin
          src = (i < 4) ? lo_src : hi_src;
          if (src >= 0) begin e[i] = 1; o[i] = m_lat[src + (i % 4)]; end
        end else if (m_reg[0][i]) begin
          e[i] = 1; o[i] = m_reg[4][i];
        end
      end
    end
    return {he, hd, e, o};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 5; k++) m_reg[k] = 0;
      m_lat = 0; exp_l = 0; exp_i = 0; exp_ain = 0;
    end else begin
      exp_l = model(1'b1);
      exp_i = model(1'b0);
      if (ale && !m_reg[3][7] && !m_reg[3][6] && m_reg[3][5]) exp_ain = pad_in;
      if (ale) m_lat = host_ad;
      if (cfg_we && cfg_addr < 5) m_reg[cfg_addr] = cfg_wdata;
    end
  end

  task automatic cmp(string who, logic [24:0] act, logic [24:0] exp, logic [7:0] a_ain);
    tests++;
    if (act !== exp || a_ain !== exp_ain) begin
      fails++;
      $display("FAIL %s %s: got hdoe/hdout/oe/out=%h ain=%h, expected %h ain=%h",
               cur_req, who, act, a_ain, exp, exp_ain);
    end
  endtask

  bit checking = 0;
  always @(negedge clk) begin
    if (checking) begin
      cmp("last", {hde_l, hd_l, oe_l, po_l}, exp_l, ain_l);
      cmp("inner", {hde_i, hd_i, oe_i, po_i}, exp_i, ain_i);
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic ale_pulse(logic [15:0] a);
    @(negedge clk); ale = 1; host_ad = a;
    @(negedge clk); host_ad = a ^ 16'h5A5A;
    @(negedge clk); ale = 0; host_ad = 16'h00C3;
    wait_n(2);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
  end

  initial begin
    wait_n(3);
    @(negedge clk); rst = 0;
    checking = 1;
    // R1: reset state
    cur_req = "R1"; wait_n(3);
    // R5: GPIO output patterns
    cur_req = "R5";
    cfg(3'd0, 8'hFF); cfg(3'd4, 8'hA5); wait_n(2);
    cfg(3'd4, 8'h3C); cfg(3'd0, 8'h0F); wait_n(2);
    // R11: unmapped address ignored
    cur_req = "R11"; cfg(3'd6, 8'hFF); cfg(3'd7, 8'h00); wait_n(2);
    // R2/R3/R4: address-out across bus types
    cur_req = "R3"; cfg(3'd1, 8'hFF); cfg(3'd0, 8'h00); ale_pulse(16'hBEEF);
    cfg(3'd0, 8'hC3); wait_n(2); cfg(3'd2, 8'h30); wait_n(2);
    cfg(3'd1, 8'h00); wait_n(2); cfg(3'd1, 8'hFF); cfg(3'd2, 8'h00); cfg(3'd0, 8'hFF);
    for (int b = 0; b < 4; b++) begin
      cur_req = "R4"; @(negedge clk); bus_type = 2'(b);
      ale_pulse(16'h1234 + 16'(b) * 16'h2F1D);
      cur_req = "R2"; ale_pulse(16'hF0E1 ^ 16'(b));
    end
    // R6: address-in capture and hold
    cur_req = "R6"; cfg(3'd3, 8'h20);
    @(negedge clk); pad_in = 8'h9B; ale_pulse(16'h0001);
    @(negedge clk); pad_in = 8'h44; wait_n(2);
    ale_pulse(16'h0002);
    // R7/R8: peripheral buffer
    cur_req = "R7"; cfg(3'd3, 8'h80);
    @(negedge clk); psel = 2'b01; wr_stb = 1; host_ad = 16'h00A7; wait_n(2);
    @(negedge clk); wr_stb = 0; rd_stb = 1; pad_in = 8'h6E; wait_n(2);
    @(negedge clk); psel = 2'b10; wr_stb = 1; wait_n(2);
    cur_req = "R8";
    @(negedge clk); psel = 2'b00; wait_n(2);
    @(negedge clk); psel = 2'b11; rd_stb = 0; wr_stb = 0; wait_n(2);
    @(negedge clk); psel = 2'b00; ale_pulse(16'h7777);
    // R9: data port
    cur_req = "R9"; cfg(3'd3, 8'h40);
    @(negedge clk); rd_stb = 1; core_rdata = 8'h5D; wait_n(2);
    @(negedge clk); rd_stb = 0; wr_stb = 1; pad_in = 8'h21; wait_n(2);
    @(negedge clk); wr_stb = 0; wait_n(2);
    // R10: priority with several mode bits set
    cur_req = "R10"; cfg(3'd3, 8'hE0);
    @(negedge clk); psel = 2'b01; wr_stb = 1; host_ad = 16'h0019; wait_n(2);
    @(negedge clk); psel = 2'b00; wait_n(2);
    cfg(3'd3, 8'h60); @(negedge clk); wr_stb = 0; rd_stb = 1; wait_n(2);
    @(negedge clk); rd_stb = 0; cfg(3'd3, 8'h00); ale_pulse(16'hA55A);
    // R1: reset again mid-run
    cur_req = "R1"; @(negedge clk); rst = 1; wait_n(2); @(negedge clk); rst = 0; wait_n(3);
    checking = 0;
    summary();
  end
endmodule